// File: doc/BRIEF.md
# Sized-Access General Register File

This block holds sixteen 64-bit general registers and lets each access pick a width: a byte, 16 bits, 32 bits or the full 64 bits. A write merges its data into the destination under sub-register rules. A 32-bit write clears the upper half of the register. Byte and 16-bit writes keep every bit they do not cover. A second byte lane, at bits 15:8, is usable only on the first four registers.

Two combinational read ports use the same width and lane selectors as the write port. Each returns the selected field right-aligned and zero-filled to 64 bits. A read that addresses the register being written in the same cycle sees the merged result at once. An access to the upper byte lane of a register that has no such lane is flagged on a single illegal-access output. An illegal write is dropped and an illegal read returns zero.

Top module: `gprf_top`

## Requirements
- R1: An active-low asynchronous reset (rst_ni low) clears all 16 registers to zero.
- R2: A write with size code 2'b11 and wr_en_i high replaces all 64 bits of the register selected by wr_idx_i with wr_data_i at the next rising clock edge.
- R3: A write with size code 2'b10 stores wr_data_i[31:0] in bits 31:0 and forces bits 63:32 to zero.
- R4: A write with size code 2'b01 stores wr_data_i[15:0] in bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with size code 2'b00 and wr_hi_i low stores wr_data_i[7:0] in bits 7:0 of any of the 16 registers and leaves bits 63:8 unchanged.
- R6: A write with size code 2'b00 and wr_hi_i high to index 0 to 3 stores wr_data_i[7:0] in bits 15:8 and leaves all other bits unchanged.
- R7: A write with size code 2'b00 and wr_hi_i high to index 4 to 15 leaves the register unchanged and drives illegal_o high in that cycle.
- R8: A read port returns the field chosen by its size code (2'b00 byte, 2'b01 16-bit, 2'b10 32-bit, 2'b11 64-bit) in its low bits and drives all higher bits to zero. A high-byte read (size 2'b00, hi high) returns bits 15:8 of the register in bits 7:0 of the output.
- R9: A high-byte read of index 4 to 15 returns zero and drives illegal_o high in that cycle.
- R10: A read port that addresses the register being legally written in the same cycle returns the merged post-write value.
- R11: With wr_en_i low no register changes. The hi flag has no effect when the size code is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Destination register index |
| wr_size_i | input | 2 | Write size code |
| wr_hi_i | input | 1 | Upper byte lane select for byte writes |
| wr_data_i | input | 64 | Write data, right-aligned |
| rd0_idx_i | input | 4 | Read port 0 index |
| rd0_size_i | input | 2 | Read port 0 size code |
| rd0_hi_i | input | 1 | Read port 0 upper byte lane select |
| rd0_data_o | output | 64 | Read port 0 data, zero-extended |
| rd1_idx_i | input | 4 | Read port 1 index |
| rd1_size_i | input | 2 | Read port 1 size code |
| rd1_hi_i | input | 1 | Read port 1 upper byte lane select |
| rd1_data_o | output | 64 | Read port 1 data, zero-extended |
| illegal_o | output | 1 | Upper byte lane used on a register that has none |

## Verification
The bench applies a chain of writes of every width to the same register. Each write lands on a value left by a wider or differently placed write, so a merge that clears or keeps the wrong bits shows up in the full-width read-back. Data with all-ones upper bits separates a 32-bit write that clears the upper half from one that keeps it. It also shows whether byte and 16-bit writes take only their own lane of the input. The same writes are checked through the bypass in their own cycle and through the other port after the edge, which tells a missing or stale bypass from a wrong merge. Reads of every width on known contents, and upper-lane accesses to legal and illegal indices, separate zero-extension, lane selection and flagging.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_B16 = 2'b01,
    SZ_B32 = 2'b10,
    SZ_B64 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/gprf_merge.sv
module gprf_merge
  import gprf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] data_i,
  input  acc_size_e       size_i,
  input  logic            hi_i,
  output logic [XLEN-1:0] new_o
);
  localparam int HALF_W = 32;

  always_comb begin
    new_o = old_i;
    case (size_i)
      SZ_B64: new_o = data_i;
      SZ_B32: new_o = {{(XLEN-HALF_W){1'b0}}, data_i[HALF_W-1:0]};
      SZ_B16: new_o[15:0] = data_i[15:0];
      default: begin
        if (hi_i) new_o[15:8] = data_i[7:0];
        else      new_o[7:0]  = data_i[7:0];
      end
    endcase
  end
endmodule

// File: rtl/gprf_extract.sv
module gprf_extract
  import gprf_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int IDX_W        = 4,
  parameter int HI_LANE_REGS = 4
) (
  input  logic [XLEN-1:0]  word_i,
  input  logic [IDX_W-1:0] idx_i,
  input  acc_size_e        size_i,
  input  logic             hi_i,
  output logic [XLEN-1:0]  data_o,
  output logic             illegal_o
);
  logic hi_sel;

  assign hi_sel    = (size_i == SZ_B8) && hi_i;
  assign illegal_o = hi_sel && (idx_i >= IDX_W'(HI_LANE_REGS));

  always_comb begin
    data_o = '0;
    case (size_i)
      SZ_B64: data_o = word_i;
      SZ_B32: data_o[31:0] = word_i[31:0];
      SZ_B16: data_o[15:0] = word_i[15:0];
      default: begin
        if (!hi_i)          data_o[7:0] = word_i[7:0];
        else if (!illegal_o) data_o[7:0] = word_i[15:8];
      end
    endcase
  end
endmodule

// File: rtl/gprf_bank.sv
module gprf_bank #(
  parameter int NUM_REGS = 16,
  parameter int XLEN     = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [XLEN-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][XLEN-1:0]  rf_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  rf_o[g] <= '0;
      else if (hit) rf_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/gprf_top.sv
module gprf_top
  import gprf_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int XLEN         = 64,
  parameter int HI_LANE_REGS = 4,
  localparam int IDX_W       = $clog2(NUM_REGS),
  localparam int NUM_RD      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_size_i,
  input  logic             wr_hi_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd0_idx_i,
  input  logic [1:0]       rd0_size_i,
  input  logic             rd0_hi_i,
  output logic [XLEN-1:0]  rd0_data_o,
  input  logic [IDX_W-1:0] rd1_idx_i,
  input  logic [1:0]       rd1_size_i,
  input  logic             rd1_hi_i,
  output logic [XLEN-1:0]  rd1_data_o,
  output logic             illegal_o
);
  logic [NUM_REGS-1:0][XLEN-1:0] rf_q;
  acc_size_e                     wr_size;
  logic                          wr_ill;
  logic                          wr_ok;
  logic [XLEN-1:0]               merged;

  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][1:0]        rd_size;
  logic [NUM_RD-1:0]             rd_hi;
  logic [NUM_RD-1:0][XLEN-1:0]   rd_data;
  logic [NUM_RD-1:0]             rd_ill;

  assign wr_size = acc_size_e'(wr_size_i);
  assign wr_ill  = wr_en_i && (wr_size == SZ_B8) && wr_hi_i
                   && (wr_idx_i >= IDX_W'(HI_LANE_REGS));
  assign wr_ok   = wr_en_i && !wr_ill;

  gprf_merge #(.XLEN(XLEN)) i_merge (
    .old_i  (rf_q[wr_idx_i]),
    .data_i (wr_data_i),
    .size_i (wr_size),
    .hi_i   (wr_hi_i),
    .new_o  (merged)
  );

  gprf_bank #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .idx_i   (wr_idx_i),
    .wdata_i (merged),
    .rf_o    (rf_q)
  );

  assign rd_idx  = {rd1_idx_i, rd0_idx_i};
  assign rd_size = {rd1_size_i, rd0_size_i};
  assign rd_hi   = {rd1_hi_i, rd0_hi_i};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [XLEN-1:0] src;
    // same-cycle write is visible to the reader
    assign src = (wr_ok && (rd_idx[p] == wr_idx_i)) ? merged : rf_q[rd_idx[p]];

    gprf_extract #(
      .XLEN(XLEN), .IDX_W(IDX_W), .HI_LANE_REGS(HI_LANE_REGS)
    ) i_ext (
      .word_i    (src),
      .idx_i     (rd_idx[p]),
      .size_i    (acc_size_e'(rd_size[p])),
      .hi_i      (rd_hi[p]),
      .data_o    (rd_data[p]),
      .illegal_o (rd_ill[p])
    );
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];
  assign illegal_o  = wr_ill | (|rd_ill);
endmodule

// File: rtl/gprf_chk.sv
module gprf_chk
  import gprf_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int XLEN         = 64,
  parameter int HI_LANE_REGS = 4,
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [IDX_W-1:0]              wr_idx_i,
  input logic [1:0]                    wr_size_i,
  input logic                          wr_hi_i,
  input logic [XLEN-1:0]               wr_data_i,
  input logic [IDX_W-1:0]              rd0_idx_i,
  input logic [1:0]                    rd0_size_i,
  input logic [XLEN-1:0]               rd0_data_o,
  input logic [IDX_W-1:0]              rd1_idx_i,
  input logic [1:0]                    rd1_size_i,
  input logic                          rd1_hi_i,
  input logic [XLEN-1:0]               rd1_data_o,
  input logic                          illegal_o,
  input logic [NUM_REGS-1:0][XLEN-1:0] rf_q
);
  logic            cur_ill, cur_wr, cur_hit0;
  logic            pv_q, pwr_q, pill_q, phi_q, phit0_q;
  logic [1:0]      psz_q;
  logic [IDX_W-1:0] pidx_q;
  logic [XLEN-1:0] pword_q, pdata_q, pbyp_q;

  assign cur_ill  = wr_en_i && (wr_size_i == SZ_B8) && wr_hi_i
                    && (wr_idx_i >= IDX_W'(HI_LANE_REGS));
  assign cur_wr   = wr_en_i && !cur_ill;
  assign cur_hit0 = (rd0_idx_i == wr_idx_i) && (rd0_size_i == SZ_B64);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0; pwr_q <= 1'b0; pill_q <= 1'b0; phi_q <= 1'b0; phit0_q <= 1'b0;
      psz_q <= '0; pidx_q <= '0; pword_q <= '0; pdata_q <= '0; pbyp_q <= '0;
    end else begin
      pv_q    <= 1'b1;
      pwr_q   <= cur_wr;
      pill_q  <= cur_ill;
      phi_q   <= wr_hi_i;
      phit0_q <= cur_wr && cur_hit0;
      psz_q   <= wr_size_i;
      pidx_q  <= wr_idx_i;
      pword_q <= rf_q[wr_idx_i];
      pdata_q <= wr_data_i;
      pbyp_q  <= rd0_data_o;
    end
  end

  assert_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pwr_q && psz_q == SZ_B64) |-> rf_q[pidx_q] == pdata_q);
  assert_upper_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pwr_q && psz_q == SZ_B32) |-> (rf_q[pidx_q][63:32] == '0 && rf_q[pidx_q][31:0] == pdata_q[31:0]));
  assert_keep16_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pwr_q && psz_q == SZ_B16) |-> rf_q[pidx_q][63:16] == pword_q[63:16]);
  assert_lobyte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pwr_q && psz_q == SZ_B8 && !phi_q) |->
      (rf_q[pidx_q][63:8] == pword_q[63:8] && rf_q[pidx_q][7:0] == pdata_q[7:0]));
  assert_hibyte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pwr_q && psz_q == SZ_B8 && phi_q) |->
      (rf_q[pidx_q][7:0] == pword_q[7:0] && rf_q[pidx_q][63:16] == pword_q[63:16]));
  assert_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pill_q) |-> rf_q[pidx_q] == pword_q);
  assert_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_ill |-> illegal_o);
  assert_zext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_size_i == SZ_B8) |-> rd0_data_o[63:8] == '0);
  assert_hi_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1_size_i == SZ_B8 && rd1_hi_i && rd1_idx_i >= IDX_W'(HI_LANE_REGS)) |->
      (rd1_data_o == '0 && illegal_o));
  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && phit0_q) |-> rf_q[pidx_q] == pbyp_q);
endmodule

bind gprf_top gprf_chk #(
  .NUM_REGS(NUM_REGS), .XLEN(XLEN), .HI_LANE_REGS(HI_LANE_REGS)
) i_chk (.*);

// File: tb/test_gprf_top.sv
module test_gprf_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic        wr_hi_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [3:0]  rd0_idx_i = '0;
  logic [1:0]  rd0_size_i = 2'b11;
  logic        rd0_hi_i = 1'b0;
  logic [63:0] rd0_data_o;
  logic [3:0]  rd1_idx_i = '0;
  logic [1:0]  rd1_size_i = 2'b11;
  logic        rd1_hi_i = 1'b0;
  logic [63:0] rd1_data_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  gprf_top i_gprf_top (.*);

  typedef struct packed {
    logic [3:0]  idx;
    logic [1:0]  sz;
    logic        hi;
    logic [63:0] d;
    logic [63:0] e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  2'b11, 1'b0, 64'h1122334455667788, 64'h1122334455667788}, // R2
    '{4'd0,  2'b10, 1'b0, 64'hFFFFFFFFAABBCCDD, 64'h00000000AABBCCDD}, // R3
    '{4'd0,  2'b01, 1'b0, 64'h123456789ABCEEFF, 64'h00000000AABBEEFF}, // R4
    '{4'd0,  2'b00, 1'b0, 64'hFFFFFFFFFFFFFF33, 64'h00000000AABBEE33}, // R5
    '{4'd0,  2'b00, 1'b1, 64'hFFFFFFFFFFFFFF5A, 64'h00000000AABB5A33}, // R6
    '{4'd3,  2'b11, 1'b0, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R2
    '{4'd3,  2'b00, 1'b1, 64'h00000000000000C4, 64'h0123456789ABC4EF}, // R6
    '{4'd15, 2'b11, 1'b0, 64'hFEDCBA9876543210, 64'hFEDCBA9876543210}, // R2
    '{4'd15, 2'b00, 1'b0, 64'h0000000000000077, 64'hFEDCBA9876543277}, // R5
    '{4'd15, 2'b01, 1'b1, 64'h000000000000ABCD, 64'hFEDCBA987654ABCD}, // R11
    '{4'd15, 2'b00, 1'b1, 64'h0000000000000099, 64'hFEDCBA987654ABCD}, // R7
    '{4'd8,  2'b10, 1'b0, 64'h8000000080000000, 64'h0000000080000000}, // R3
    '{4'd7,  2'b11, 1'b1, 64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D}  // R11
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd0(input logic [3:0] idx, input logic [1:0] sz, input logic hi);
    rd0_idx_i = idx; rd0_size_i = sz; rd0_hi_i = hi;
  endtask

  task automatic rd1(input logic [3:0] idx, input logic [1:0] sz, input logic hi);
    rd1_idx_i = idx; rd1_size_i = sz; rd1_hi_i = hi;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state of every register
    for (int i = 0; i < 16; i++) begin
      rd0(4'(i), 2'b11, 1'b0);
      #1 chk("R1", rd0_data_o, 64'h0);
    end

    for (int v = 0; v < NV; v++) begin
      logic exp_ill;
      @(negedge clk_i);
      exp_ill = (VECS[v].sz == 2'b00) && VECS[v].hi && (VECS[v].idx >= 4'd4);
      wr_en_i = 1'b1; wr_idx_i = VECS[v].idx; wr_size_i = VECS[v].sz;
      wr_hi_i = VECS[v].hi; wr_data_i = VECS[v].d;
      rd0(VECS[v].idx, 2'b11, 1'b0);
      rd1(VECS[v].idx, 2'b11, 1'b0);
      #1;
      chk("R10 bypass", rd0_data_o, VECS[v].e);
      chk("R7 flag", 64'(illegal_o), 64'(exp_ill));
      @(negedge clk_i);
      wr_en_i = 1'b0;
      #1;
      chk("R2-6 merge", rd1_data_o, VECS[v].e);
      chk("R7 flag idle", 64'(illegal_o), 64'h0);
    end

    // R8: sized reads of reg0 = 00000000AABB5A33 and reg3 = 0123456789ABC4EF
    rd0(4'd0, 2'b00, 1'b0); rd1(4'd0, 2'b00, 1'b1);
    #1 chk("R8 lo byte", rd0_data_o, 64'h33);
    chk("R8 hi byte", rd1_data_o, 64'h5A);
    chk("R8 no flag", 64'(illegal_o), 64'h0);
    rd0(4'd0, 2'b01, 1'b0); rd1(4'd0, 2'b10, 1'b0);
    #1 chk("R8 16-bit", rd0_data_o, 64'h5A33);
    chk("R8 32-bit", rd1_data_o, 64'hAABB5A33);
    rd0(4'd3, 2'b10, 1'b1); rd1(4'd3, 2'b00, 1'b1);
    #1 chk("R11 hi ignored on read", rd0_data_o, 64'h89ABC4EF);
    chk("R8 hi byte reg3", rd1_data_o, 64'hC4);

    // R9: high-byte read of a register with no upper lane
    rd0(4'd0, 2'b11, 1'b0); rd1(4'd15, 2'b00, 1'b1);
    #1 chk("R9 data", rd1_data_o, 64'h0);
    chk("R9 flag", 64'(illegal_o), 64'h1);
    rd1(4'd4, 2'b00, 1'b1);
    #1 chk("R9 data idx4", rd1_data_o, 64'h0);
    chk("R9 flag idx4", 64'(illegal_o), 64'h1);
    rd1(4'd7, 2'b11, 1'b0);

    // R11: disabled write leaves reg0 unchanged
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_idx_i = 4'd0; wr_size_i = 2'b11; wr_data_i = '1;
    @(negedge clk_i);
    #1 chk("R11 no write", rd0_data_o, 64'h00000000AABB5A33);

    // R1: asynchronous reset mid-cycle
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #1 chk("R1 async", rd1_data_o, 64'h0);
    chk("R1 async reg0", rd0_data_o, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule